// File: doc/BRIEF.md
# PCM Serial Port with Frame-Sync Detection

This block is the digital half of a telephony codec's serial data port. On the transmit side it takes an 8-bit companded sample word and presents it in parallel. It then shifts the word out, sign bit first, on a data pin with a separate output enable. The shift happens during the time slot that a transmit frame sync marks. An active-low slot strobe stays low for as long as the data pin is driven. On the receive side it collects 8 serial bits after a receive frame sync. It then presents them as a parallel word with a one-cycle valid pulse.

Two sync shapes are accepted. A short sync is one bit period wide. A long sync lasts three bit periods or more. The block measures the width of each transmit sync that opens a frame and uses the result for the frames that follow. Each shape has its own rules for when the output turns on and off. The receive half follows the mode that the transmit side sensed. All logic runs on one fast system clock. The bit clocks, the syncs and the serial input are synchronized into that clock and edge-detected. Bit clocks from 64 kHz to 2.048 MHz can be used when the system clock is fast enough.

Top module: `pcm_slot_port`

## Requirements
- R1: Each transmit slot drives exactly 8 bits, most significant (sign) bit first. A new bit is presented after each bit-clock rising edge.
- R2: Short-sync rule. If the transmit sync is high at a bit-clock falling edge, the next rising edge turns `tx_oe` on and drives the sign bit. The falling edge after the eighth bit turns `tx_oe` off.
- R3: Mode sensing. When a frame-opening transmit sync ends, the port counts the bit-clock falling edges that saw it high. Three or more selects long mode and fewer selects short mode. The new mode applies from the next frame onward.
- R4: Long-sync enable. In long mode `tx_oe` turns on at the sync rising edge or at the bit-clock rising edge, whichever comes later, and the sign bit goes out first.
- R5: Long-sync disable. In long mode `tx_oe` turns off at the falling edge after the eighth bit or when the sync goes low, whichever comes later.
- R6: Receive. In short mode, the 8 bit-clock falling edges after the arming edge latch `rx_din`. In long mode, the 8 falling edges after the sync rising edge latch it. The first bit latched is bit 7. `rx_word` then updates and `rx_valid` is high for exactly one system clock.
- R7: After reset the port is in short mode, `tx_oe` is 0, `slot_n` is 1 and `rx_valid` is 0. The word queued for the first slot is 8'hFF.
- R8: The word on `tx_word` is sampled when a frame opens and is sent in the next frame, one frame later.
- R9: A sync that rises while a frame is in progress is ignored by both halves. It does not restart the frame, does not resample `tx_word` and does not change the mode.
- R10: `slot_n` is low exactly while `tx_oe` is high.
- R11: The receive half uses the mode sensed from the transmit sync. It never measures the receive sync width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clocks |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_fsync | input | 1 | Transmit frame sync |
| tx_word | input | 8 | Parallel sample to be sent |
| tx_dout | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Enable for the tri-state transmit driver |
| slot_n | output | 1 | Active-low transmit slot strobe (open-drain pull-down) |
| rx_bclk | input | 1 | Receive bit clock |
| rx_fsync | input | 1 | Receive frame sync |
| rx_din | input | 1 | Serial receive data |
| rx_word | output | 8 | Last received word |
| rx_valid | output | 1 | One-cycle pulse when `rx_word` updates |

## Verification
When the two syncs are aligned and share one bit clock, two events fall on the same synchronized falling edge. The receive side latches its eighth bit and raises `rx_valid`, and the transmit side turns `tx_oe` off. This happens in both short and long mode. Every frame in the bench is built this way. The bench judges the two results separately. `rx_valid` must appear once with the expected word. `tx_oe` must read low at mid-low of the period after the eighth bit, or stay high while a long transmit sync is still asserted.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

  typedef enum logic [1:0] {TX_IDLE, TX_WAIT, TX_SEND} tx_state_t;
  typedef enum logic       {RX_IDLE, RX_RECV}          rx_state_t;

  // sync width (in falling bit-clock edges) to mode decision
  function automatic logic sync_is_long(input int edges, input int min_edges);
    return edges >= min_edges;
  endfunction

  // bits to serialise: shift a word left, filling with zero
  function automatic logic [7:0] shift_out(input logic [7:0] w);
    return {w[6:0], 1'b0};
  endfunction

endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] pipe [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= '0;
    else        pipe[0] <= in_raw;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[s] <= '0;
      else        pipe[s] <= pipe[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= pipe[STAGES-1];
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/pcm_tx.sv
module pcm_tx
  import pcm_pkg::*;
#(
  parameter int           WORD_W    = 8,
  parameter int           LONG_MIN  = 3,
  parameter logic [7:0]   IDLE_WORD = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bx_lvl,
  input  logic              bx_rise,
  input  logic              bx_fall,
  input  logic              fx_lvl,
  input  logic              fx_rise,
  input  logic              fx_fall,
  input  logic [WORD_W-1:0] tx_word,
  output logic              dout,
  output logic              oe,
  output logic              mode_long
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam int SC_W  = $clog2(LONG_MIN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W);

  tx_state_t         state;
  logic [WORD_W-1:0] shreg, hold;
  logic [CNT_W-1:0]  sent;
  logic [SC_W-1:0]   sync_cnt;
  logic              owned, frame_long, tail_seen;

  // named events for the assertions
  logic start_evt, last_fall;
  assign start_evt = (state == TX_IDLE) &&
                     (mode_long ? fx_rise : (bx_fall && fx_lvl));
  assign last_fall = (state == TX_SEND) && bx_fall && (sent == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= TX_IDLE; shreg <= '0; hold <= IDLE_WORD; sent <= '0;
      sync_cnt <= '0; owned <= 1'b0; frame_long <= 1'b0; tail_seen <= 1'b0;
      mode_long <= 1'b0; oe <= 1'b0; dout <= 1'b0;
    end else begin
      // sync width measurement, committed only for the frame-opening sync
      if (fx_rise) sync_cnt <= bx_fall ? SC_W'(1) : '0;
      else if (bx_fall && fx_lvl && sync_cnt != SC_W'(LONG_MIN))
        sync_cnt <= sync_cnt + 1'b1;
      if (fx_fall && owned) begin
        mode_long <= sync_is_long(int'(sync_cnt), LONG_MIN);
        owned     <= 1'b0;
      end

      unique case (state)
        TX_IDLE: if (start_evt) begin
          hold <= tx_word; owned <= 1'b1; frame_long <= mode_long;
          tail_seen <= 1'b0;
          if (mode_long && bx_lvl) begin
            oe <= 1'b1; dout <= hold[WORD_W-1];
            shreg <= shift_out(hold); sent <= CNT_W'(1); state <= TX_SEND;
          end else begin
            shreg <= hold; sent <= '0; state <= TX_WAIT;
          end
        end
        TX_WAIT: if (bx_rise) begin
          oe <= 1'b1; dout <= shreg[WORD_W-1];
          shreg <= shift_out(shreg); sent <= CNT_W'(1); state <= TX_SEND;
        end
        TX_SEND: begin
          if (bx_rise && sent != LAST) begin
            dout <= shreg[WORD_W-1]; shreg <= shift_out(shreg);
            sent <= sent + 1'b1;
          end
          if (frame_long) begin
            if (last_fall) tail_seen <= 1'b1;
            if ((tail_seen || last_fall) && !fx_lvl) begin
              oe <= 1'b0; dout <= 1'b0; state <= TX_IDLE;
            end
          end else if (last_fall) begin
            oe <= 1'b0; dout <= 1'b0; state <= TX_IDLE;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  // R2: short slot closes on the falling edge after bit eight
  a_r2_short_close: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && !frame_long && last_fall) |=> !oe);
  // R5: a long slot stays open while the sync is still high
  a_r5_long_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && frame_long && fx_lvl) |=> oe);
  // R1: the output only closes after eight bits went out
  a_r1_eight_bits: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe) |-> (sent == LAST));
  // R3: the mode only changes right after a sync falls
  a_r3_mode_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !fx_fall |=> $stable(mode_long));
endmodule

// File: rtl/pcm_rx.sv
module pcm_rx
  import pcm_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_fall,
  input  logic              fr_lvl,
  input  logic              fr_rise,
  input  logic              din,
  input  logic              mode_long,
  output logic [WORD_W-1:0] word,
  output logic              valid
);
  localparam int CNT_W = $clog2(WORD_W);

  rx_state_t         state;
  logic [WORD_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;

  logic start_evt;
  assign start_evt = (state == RX_IDLE) &&
                     (mode_long ? fr_rise : (br_fall && fr_lvl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE; sh <= '0; cnt <= '0; word <= '0; valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      unique case (state)
        RX_IDLE: if (start_evt) begin
          cnt <= '0; state <= RX_RECV;
        end
        RX_RECV: if (br_fall) begin
          sh <= {sh[WORD_W-2:0], din};
          if (cnt == CNT_W'(WORD_W - 1)) begin
            word <= {sh[WORD_W-2:0], din}; valid <= 1'b1; state <= RX_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R6: the valid strobe is a single system-clock pulse
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  // R6: a word is only delivered on a bit-clock falling edge
  a_r6_valid_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(br_fall));
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port #(
  parameter int         WORD_W      = 8,
  parameter int         LONG_MIN    = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] IDLE_WORD   = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_bclk,
  input  logic              tx_fsync,
  input  logic [WORD_W-1:0] tx_word,
  output logic              tx_dout,
  output logic              tx_oe,
  output logic              slot_n,
  input  logic              rx_bclk,
  input  logic              rx_fsync,
  input  logic              rx_din,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid
);
  logic [1:0] xs_lvl, xs_rise, xs_fall;   // {fsync, bclk}
  logic [2:0] rs_lvl, rs_rise, rs_fall;   // {din, fsync, bclk}
  logic       mode_long;

  pcm_edge_sync #(.W(2), .STAGES(SYNC_STAGES)) u_xsync (
    .clk, .rst_n, .in_raw({tx_fsync, tx_bclk}),
    .lvl(xs_lvl), .rise(xs_rise), .fall(xs_fall));

  pcm_edge_sync #(.W(3), .STAGES(SYNC_STAGES)) u_rsync (
    .clk, .rst_n, .in_raw({rx_din, rx_fsync, rx_bclk}),
    .lvl(rs_lvl), .rise(rs_rise), .fall(rs_fall));

  pcm_tx #(.WORD_W(WORD_W), .LONG_MIN(LONG_MIN), .IDLE_WORD(IDLE_WORD)) u_tx (
    .clk, .rst_n,
    .bx_lvl(xs_lvl[0]), .bx_rise(xs_rise[0]), .bx_fall(xs_fall[0]),
    .fx_lvl(xs_lvl[1]), .fx_rise(xs_rise[1]), .fx_fall(xs_fall[1]),
    .tx_word, .dout(tx_dout), .oe(tx_oe), .mode_long);

  pcm_rx #(.WORD_W(WORD_W)) u_rx (
    .clk, .rst_n, .br_fall(rs_fall[0]), .fr_lvl(rs_lvl[1]),
    .fr_rise(rs_rise[1]), .din(rs_lvl[2]), .mode_long,
    .word(rx_word), .valid(rx_valid));

  assign slot_n = ~tx_oe;

  logic unused_edges;
  assign unused_edges = ^{rs_lvl[0], rs_rise[0], rs_rise[2], rs_fall[2:1]};

  // R10: strobe and output enable never disagree
  a_r10_slot_tracks_oe: assert property (@(posedge clk) disable iff (!rst_n)
    slot_n != tx_oe);
endmodule

// File: tb/pcm_slot_port_tb.sv
module pcm_slot_port_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bclk = 1'b1, fsx = 1'b0, fsr = 1'b0, din = 1'b0;
  logic [7:0] tx_word = 8'h00;
  logic tx_dout, tx_oe, slot_n, rx_valid;
  logic [7:0] rx_word;

  int checks = 0, fails = 0;
  logic [7:0] tx_q [$];
  logic [7:0] rx_q [$];
  logic [7:0] prev_tx = 8'hFF;   // R7 idle word

  always #10 clk = ~clk;

  pcm_slot_port dut_i (
    .clk, .rst_n, .tx_bclk(bclk), .tx_fsync(fsx), .tx_word,
    .tx_dout, .tx_oe, .slot_n, .rx_bclk(bclk), .rx_fsync(fsr), .rx_din(din),
    .rx_word, .rx_valid);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: transmit bits sampled on each bit-clock fall while enabled
  int nb = 0; logic [7:0] cap = 0;
  always @(negedge bclk) begin
    if (tx_oe) begin
      if (nb < 8) begin
        cap = {cap[6:0], tx_dout}; nb++;
        if (nb == 8) begin
          if (tx_q.size() == 0) chk(0, "R1/R8 unexpected tx word", cap, 0);
          else begin
            logic [7:0] e; e = tx_q.pop_front();
            chk(cap == e, "R1/R8 tx word", cap, e);
          end
        end
      end
    end else nb = 0;
  end

  // monitor: received words
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (rx_q.size() == 0) chk(0, "R6 unexpected rx word", rx_word, 0);
      else begin
        logic [7:0] e; e = rx_q.pop_front();
        chk(rx_word == e, "R6/R11 rx word", rx_word, e);
      end
    end
  end

  // expected enable at mid-low of period p (R2, R4, R5)
  function automatic bit exp_oe(input bit lsched, input int xlen, input int p);
    if (!lsched) return (p >= 1 && p <= 7);
    return p < ((xlen > 7) ? xlen : 7);
  endfunction

  // driver: one frame of 12 bit periods, sync rising in period 0
  task automatic frame(input logic [7:0] txw, input logic [7:0] rxw,
                       input int xlen, input int rlen, input bit lsched,
                       input bit spur, input string tag);
    tx_q.push_back(prev_tx); prev_tx = txw;
    rx_q.push_back(rxw);
    tx_word = txw;
    for (int p = 0; p < 12; p++) begin
      @(negedge clk) bclk = 1'b1;
      repeat (2) @(negedge clk);
      if (p == 0) begin fsx = 1'b1; fsr = 1'b1; end
      if (p == xlen) fsx = 1'b0;
      if (p == rlen) fsr = 1'b0;
      if (spur && p == 4) begin fsx = 1'b1; fsr = 1'b1; tx_word = ~txw; end
      if (spur && p == 5) begin fsx = 1'b0; fsr = 1'b0; tx_word = txw; end
      begin
        int idx; idx = lsched ? p : p - 1;
        if (idx >= 0 && idx < 8) din = rxw[7-idx];
      end
      repeat (6) @(negedge clk);
      bclk = 1'b0;
      repeat (6) @(negedge clk);
      chk(tx_oe == exp_oe(lsched, xlen, p), {tag, " oe timing"}, tx_oe,
          exp_oe(lsched, xlen, p));
      chk(slot_n == !tx_oe, "R10 slot strobe", slot_n, !tx_oe);
      repeat (2) @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(tx_oe == 1'b0, "R7 reset oe", tx_oe, 0);
    chk(slot_n == 1'b1, "R7 reset slot_n", slot_n, 1);
    chk(rx_valid == 1'b0, "R7 reset rx_valid", rx_valid, 0);
    // short frames; first sends the idle word (R7, R8)
    frame(8'hA5, 8'h3C, 1, 1, 0, 0, "R2 short");
    frame(8'h5A, 8'hC3, 1, 1, 0, 0, "R2 short");
    // mid-frame sync pulse must be ignored (R9)
    frame(8'h81, 8'h7E, 1, 1, 0, 1, "R9 spurious");
    frame(8'h0F, 8'hF0, 1, 1, 0, 0, "R9 after spurious");
    // long sync while still short: short rules, then mode turns long (R3)
    frame(8'h96, 8'h69, 4, 4, 0, 0, "R3 sensing frame");
    frame(8'h3C, 8'hA5, 4, 4, 1, 0, "R4 long");
    // long sync outlasting the eighth bit (R5); rx follows tx mode (R11)
    frame(8'hE7, 8'h18, 10, 4, 1, 0, "R5 long late sync");
    // short sync in long mode: long rules, mode reverts (R3)
    frame(8'h24, 8'hDB, 1, 1, 1, 0, "R3 revert frame");
    frame(8'h00, 8'hFF, 1, 1, 0, 0, "R3 short again");
    repeat (20) @(negedge clk);
    chk(tx_q.size() == 0, "R1 tx words outstanding", tx_q.size(), 0);
    chk(rx_q.size() == 0, "R6 rx words outstanding", rx_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule